// File: doc/BRIEF.md
# Multicycle Sequencer with Two Instruction Lengths

This block is the control core of a small multicycle processor. It has sixteen general registers and a 16-bit ALU, and it reads its program from a synchronous instruction port that is 32 bits wide. Each instruction is either a 20-bit register form or a 32-bit memory form. The two lengths are packed back to back with no padding, so an instruction may start at any nibble and may cross a word boundary. To handle this, the instruction pointer counts in nibbles. The fetch logic reads two adjacent words and cuts the instruction out of that 64-bit window.

Every instruction goes through the same fixed steps. The core fetches it, advances the pointer by the instruction's length, splits the instruction into field registers and then executes it. After each execution step a check stage examines the status word. A set error flag stops the core, and so does a halt instruction. After that the `halted` output stays high until reset, and no further fetches or data accesses take place.

Top module: `nib_seq_core`

## Requirements
- R1: A synchronous active-low reset clears everything: the instruction pointer, all sixteen registers, the status word and the halt state. While reset is held, `halted` is 0, `psw` is 0 and `imem_addr` is 0.
- R2: Nibble `k` of instruction word `w` sits at bits `[31-4k -: 4]` and is at nibble address `8w+k`. Instructions are read from their first nibble onward. Op code bit 7 set selects the 32-bit form, with fields op[31:24], rA[23:20], rB[19:16] and a 16-bit operand in [15:0]. Bit 7 clear selects the 20-bit form, with fields op[19:12], rA[11:8], rB[7:4] and rD[3:0]. The pointer advances by 8 after a 32-bit instruction and by 5 after a 20-bit one, and an instruction may cross a word boundary.
- R3: The steps take one cycle each: word request, first word, second word, pointer advance, field decode, execute, status check. A lone halt at address 0 therefore raises `halted` on the 7th rising edge after reset is released.
- R4: The register ops write rD: ADD 0x01 (rA+rB), AND 0x02, OR 0x03, XOR 0x04, NOT 0x05 (~rA) and compare-equal 0x09, which writes 1 when rA equals rB and 0 otherwise.
- R5: The shifts shift rA by rB[3:0] and write rD. SHL 0x06 shifts left with zero fill. SHR 0x07 shifts right with zero fill. SAR 0x08 shifts right and fills with copies of the sign bit.
- R6: LOAD 0x80 reads the data word at the 16-bit operand into rA. STORE 0x81 writes rA to the data word at the operand. Read data returns one cycle after the request.
- R7: JMP 0x82 always loads the operand into the instruction pointer as a nibble address.
- R8: BRT 0x83 loads the operand into the pointer only when rA is nonzero. Otherwise execution continues with the next instruction.
- R9: HALT 0x00 stops all fetching and data access. `halted` then stays 1 until reset, and `imem_addr` stays constant.
- R10: Every register op updates `psw` = {err[4], ovf[3], neg[2], carry[1], zero[0]}. Zero and neg come from the result. Carry and ovf are the unsigned carry and the signed overflow of ADD, and they are 0 for every other register op. Memory, branch and halt ops leave the flags unchanged.
- R11: An undefined op code sets err (bit 4). The check stage then halts the core, and no later instruction executes. Err stays set until reset.
- R12: Register 0 is an ordinary register that can be written and read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | IP_W-3 | Instruction word address |
| imem_rdata | input | 32 | Instruction word, valid the cycle after its address |
| dmem_addr | output | DA_W | Data word address |
| dmem_wdata | output | DW | Store data |
| dmem_we | output | 1 | Data write strobe |
| dmem_re | output | 1 | Data read strobe |
| dmem_rdata | input | DW | Load data, valid the cycle after `dmem_re` |
| halted | output | 1 | Core stopped (halt op or error) |
| psw | output | 5 | Status flags {err, ovf, neg, carry, zero} |

## Verification
A wrong pointer step or a wrong window offset cuts every following instruction from the wrong nibbles. This shows up within a few instructions as stores of wrong values, as stores to wrong addresses, or as a false illegal-op halt. A wrong state sequence moves the `halted` edge away from its fixed cycle, or reads data before it arrives. A stuck flag or register shows up in `psw` once the program halts, or in the next value stored through the data port.

// File: rtl/nib_seq_pkg.sv
// Shared constants and types for the nibble-addressed sequencer.
// Assumes 32-bit instruction words and 8-bit op codes whose bit 7 selects
// the long (32-bit) format.
package nib_seq_pkg;

    localparam int INSTR_W   = 32;
    localparam int LEN_SHORT = 5;
    localparam int LEN_LONG  = 8;

    localparam logic [7:0] OP_HALT  = 8'h00;
    localparam logic [7:0] OP_ADD   = 8'h01;
    localparam logic [7:0] OP_AND   = 8'h02;
    localparam logic [7:0] OP_OR    = 8'h03;
    localparam logic [7:0] OP_XOR   = 8'h04;
    localparam logic [7:0] OP_NOT   = 8'h05;
    localparam logic [7:0] OP_SHL   = 8'h06;
    localparam logic [7:0] OP_SHR   = 8'h07;
    localparam logic [7:0] OP_SAR   = 8'h08;
    localparam logic [7:0] OP_CEQ   = 8'h09;
    localparam logic [7:0] OP_LOAD  = 8'h80;
    localparam logic [7:0] OP_STORE = 8'h81;
    localparam logic [7:0] OP_JMP   = 8'h82;
    localparam logic [7:0] OP_BRT   = 8'h83;

    typedef enum logic [3:0] {
        ST_F0, ST_F1, ST_F2, ST_INC, ST_DEC, ST_EXE, ST_MEM, ST_CHK, ST_HALT
    } seq_state_t;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_AND, ALU_OR, ALU_XOR, ALU_NOT,
        ALU_SHL, ALU_SHR, ALU_SAR, ALU_CEQ
    } alu_fn_t;

    typedef struct packed {
        logic err;
        logic ovf;
        logic neg;
        logic cry;
        logic zero;
    } psw_t;

endpackage

// File: rtl/nib_seq_align.sv
// Cuts one instruction out of a two-word window at a nibble offset.
// Assumes the window holds the word at the pointer in its upper half and the
// following word in its lower half; nibbles are read from the top down.
module nib_seq_align
    import nib_seq_pkg::*;
#(
    parameter int WORD_W = INSTR_W
) (
    input  logic [2*WORD_W-1:0] window,
    input  logic [2:0]          nib_off,
    output logic [WORD_W-1:0]   instr,
    output logic                is_long
);
    localparam int NOFF = WORD_W / 4;

    logic [WORD_W-1:0] cand [NOFF];

    // One candidate per possible start nibble.
    for (genvar k = 0; k < NOFF; k++) begin : g_cand
        assign cand[k] = window[2*WORD_W-1-4*k -: WORD_W];
    end

    // Pick the candidate for the current offset; bit 7 of the op code gives the length.
    always_comb begin
        instr   = cand[nib_off];
        is_long = instr[WORD_W-1];
    end
endmodule

// File: rtl/nib_seq_decode.sv
// Classifies an op code into an operation group and an ALU function.
// Assumes exactly one group flag is set for any op code; unknown codes set illegal.
module nib_seq_decode
    import nib_seq_pkg::*;
(
    input  logic [7:0] opc,
    output alu_fn_t    alu_fn,
    output logic       is_alu,
    output logic       is_load,
    output logic       is_store,
    output logic       is_jmp,
    output logic       is_brt,
    output logic       is_halt,
    output logic       is_illegal
);
    // Op code table lookup.
    always_comb begin
        alu_fn     = ALU_ADD;
        is_alu     = 1'b0;
        is_load    = 1'b0;
        is_store   = 1'b0;
        is_jmp     = 1'b0;
        is_brt     = 1'b0;
        is_halt    = 1'b0;
        is_illegal = 1'b0;
        case (opc)
            OP_HALT:  is_halt = 1'b1;
            OP_ADD:   begin is_alu = 1'b1; alu_fn = ALU_ADD; end
            OP_AND:   begin is_alu = 1'b1; alu_fn = ALU_AND; end
            OP_OR:    begin is_alu = 1'b1; alu_fn = ALU_OR;  end
            OP_XOR:   begin is_alu = 1'b1; alu_fn = ALU_XOR; end
            OP_NOT:   begin is_alu = 1'b1; alu_fn = ALU_NOT; end
            OP_SHL:   begin is_alu = 1'b1; alu_fn = ALU_SHL; end
            OP_SHR:   begin is_alu = 1'b1; alu_fn = ALU_SHR; end
            OP_SAR:   begin is_alu = 1'b1; alu_fn = ALU_SAR; end
            OP_CEQ:   begin is_alu = 1'b1; alu_fn = ALU_CEQ; end
            OP_LOAD:  is_load  = 1'b1;
            OP_STORE: is_store = 1'b1;
            OP_JMP:   is_jmp   = 1'b1;
            OP_BRT:   is_brt   = 1'b1;
            default:  is_illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/nib_seq_alu.sv
// Combinational ALU: logic ops, add with carry/overflow, three shifts, equality.
// Assumes the shift amount is the low log2(W) bits of operand b.
module nib_seq_alu
    import nib_seq_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_fn_t      fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         cout,
    output logic         ovf
);
    localparam int SH_W = $clog2(W);

    logic [W:0]      sum;
    logic [SH_W-1:0] sh;

    // Operation select and flag generation.
    always_comb begin
        sum  = {1'b0, a} + {1'b0, b};
        sh   = b[SH_W-1:0];
        cout = 1'b0;
        ovf  = 1'b0;
        case (fn)
            ALU_ADD: begin
                y    = sum[W-1:0];
                cout = sum[W];
                ovf  = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
            end
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            ALU_NOT: y = ~a;
            ALU_SHL: y = a << sh;
            ALU_SHR: y = a >> sh;
            ALU_SAR: y = W'($signed(a) >>> sh);
            ALU_CEQ: y = (a == b) ? W'(1) : '0;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/nib_seq_regfile.sv
// General register file: two combinational read ports, one write port.
// Assumes synchronous active-low reset clears every entry; no entry is special.
module nib_seq_regfile #(
    parameter int W = 16,
    parameter int N = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] waddr,
    input  logic [W-1:0]         wdata,
    input  logic [$clog2(N)-1:0] raddr_a,
    input  logic [$clog2(N)-1:0] raddr_b,
    output logic [W-1:0]         rdata_a,
    output logic [W-1:0]         rdata_b
);
    localparam int AW = $clog2(N);

    logic [W-1:0] regs [N];

    // Register storage with reset and single write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (we && waddr == AW'(i))
                regs[i] <= wdata;
        end
    end

    // Read ports.
    always_comb begin
        rdata_a = regs[raddr_a];
        rdata_b = regs[raddr_b];
    end
endmodule

// File: rtl/nib_seq_core.sv
// Multicycle sequencer top: nibble-addressed fetch of 20/32-bit instructions,
// field decode into separate registers, execute, and a status check after
// every execution. Assumes synchronous instruction and data reads (data one
// cycle after the address) and IP_W, DA_W no wider than the 16-bit operand.
module nib_seq_core
    import nib_seq_pkg::*;
#(
    parameter int DW    = 16,
    parameter int NREG  = 16,
    parameter int IP_W  = 16,
    parameter int DA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [IP_W-4:0]   imem_addr,
    input  logic [31:0]       imem_rdata,
    output logic [DA_W-1:0]   dmem_addr,
    output logic [DW-1:0]     dmem_wdata,
    output logic              dmem_we,
    output logic              dmem_re,
    input  logic [DW-1:0]     dmem_rdata,
    output logic              halted,
    output logic [4:0]        psw
);
    localparam int RA_W  = $clog2(NREG);
    localparam int WA_W  = IP_W - 3;
    localparam int OPD_W = 16;

    seq_state_t            state;
    logic [IP_W-1:0]       ip;
    logic [INSTR_W-1:0]    win_hi, win_lo, ir;
    logic [7:0]            opc;
    logic [RA_W-1:0]       fa, fb, fd;
    logic [OPD_W-1:0]      imm;
    psw_t                  psw_q;
    logic                  halt_req;
    logic                  inc_stage;

    logic [INSTR_W-1:0]    cut_instr;
    logic                  cut_long;
    alu_fn_t               alu_fn;
    logic                  d_alu, d_load, d_store, d_jmp, d_brt, d_halt, d_ill;
    logic [DW-1:0]         ra_val, rb_val, alu_y;
    logic                  alu_c, alu_v;
    logic                  rf_we;
    logic [RA_W-1:0]       rf_waddr;
    logic [DW-1:0]         rf_wdata;

    nib_seq_align u_align (
        .window  ({win_hi, win_lo}),
        .nib_off (ip[2:0]),
        .instr   (cut_instr),
        .is_long (cut_long)
    );

    nib_seq_decode u_dec (
        .opc        (opc),
        .alu_fn     (alu_fn),
        .is_alu     (d_alu),
        .is_load    (d_load),
        .is_store   (d_store),
        .is_jmp     (d_jmp),
        .is_brt     (d_brt),
        .is_halt    (d_halt),
        .is_illegal (d_ill)
    );

    nib_seq_regfile #(.W(DW), .N(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (fa),
        .raddr_b (fb),
        .rdata_a (ra_val),
        .rdata_b (rb_val)
    );

    nib_seq_alu #(.W(DW)) u_alu (
        .fn   (alu_fn),
        .a    (ra_val),
        .b    (rb_val),
        .y    (alu_y),
        .cout (alu_c),
        .ovf  (alu_v)
    );

    assign inc_stage = (state == ST_INC);

    // Register write port: ALU result in execute, load data in the memory step.
    always_comb begin
        rf_we    = (state == ST_EXE && d_alu) || (state == ST_MEM);
        rf_waddr = (state == ST_MEM) ? fa : fd;
        rf_wdata = (state == ST_MEM) ? dmem_rdata : alu_y;
    end

    // External strobes and addresses derived from the current step.
    always_comb begin
        imem_addr  = (state == ST_F1) ? ip[IP_W-1:3] + WA_W'(1) : ip[IP_W-1:3];
        dmem_addr  = imm[DA_W-1:0];
        dmem_wdata = ra_val;
        dmem_we    = (state == ST_EXE) && d_store;
        dmem_re    = (state == ST_EXE) && d_load;
        halted     = (state == ST_HALT);
        psw        = psw_q;
    end

    // Step sequencer: fetch, advance pointer, decode fields, execute, check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_F0;
            ip       <= '0;
            win_hi   <= '0;
            win_lo   <= '0;
            ir       <= '0;
            opc      <= '0;
            fa       <= '0;
            fb       <= '0;
            fd       <= '0;
            imm      <= '0;
            psw_q    <= '0;
            halt_req <= 1'b0;
        end else begin
            case (state)
                ST_F0: state <= ST_F1;
                ST_F1: begin
                    win_hi <= imem_rdata;
                    state  <= ST_F2;
                end
                ST_F2: begin
                    win_lo <= imem_rdata;
                    state  <= ST_INC;
                end
                ST_INC: begin
                    ir    <= cut_instr;
                    ip    <= ip + (cut_long ? IP_W'(LEN_LONG) : IP_W'(LEN_SHORT));
                    state <= ST_DEC;
                end
                ST_DEC: begin
                    opc <= ir[31:24];
                    imm <= ir[15:0];
                    if (ir[31]) begin
                        fa <= ir[23:20];
                        fb <= ir[19:16];
                        fd <= '0;
                    end else begin
                        fa <= ir[23:20];
                        fb <= ir[19:16];
                        fd <= ir[15:12];
                    end
                    state <= ST_EXE;
                end
                ST_EXE: begin
                    if (d_alu) begin
                        psw_q.zero <= (alu_y == '0);
                        psw_q.neg  <= alu_y[DW-1];
                        psw_q.cry  <= alu_c;
                        psw_q.ovf  <= alu_v;
                    end
                    if (d_jmp || (d_brt && ra_val != '0))
                        ip <= imm[IP_W-1:0];
                    if (d_halt)
                        halt_req <= 1'b1;
                    if (d_ill)
                        psw_q.err <= 1'b1;
                    state <= d_load ? ST_MEM : ST_CHK;
                end
                ST_MEM: state <= ST_CHK;
                ST_CHK: state <= (psw_q.err || halt_req) ? ST_HALT : ST_F0;
                ST_HALT: state <= ST_HALT;
                default: state <= ST_HALT;
            endcase
        end
    end
endmodule

// File: rtl/nib_seq_checker.sv
// Property checker for nib_seq_core, attached by bind below.
// Assumes it sees the top's ports plus the pointer and its advance step.
module nib_seq_checker #(
    parameter int IP_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            halted,
    input logic [IP_W-4:0] imem_addr,
    input logic            dmem_we,
    input logic            dmem_re,
    input logic            err,
    input logic [IP_W-1:0] ip,
    input logic            ip_step
);
    a_r2_ip_step: assert property (@(posedge clk) disable iff (!rst_n)
        ip_step |=> (ip == $past(ip) + IP_W'(5)) || (ip == $past(ip) + IP_W'(8)));

    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    a_r9_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(imem_addr));

    a_r9_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !dmem_we && !dmem_re);

    a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_we && dmem_re));

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    a_r11_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |=> halted);
endmodule

bind nib_seq_core nib_seq_checker #(.IP_W(IP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .halted    (halted),
    .imem_addr (imem_addr),
    .dmem_we   (dmem_we),
    .dmem_re   (dmem_re),
    .err       (psw[4]),
    .ip        (ip),
    .ip_step   (inc_stage)
);

// File: tb/sim_nib_seq_core.sv
module sim_nib_seq_core;
    import nib_seq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] imem_addr;
    logic [31:0] imem_rdata;
    logic [15:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, dmem_re, halted;
    logic [4:0]  psw;

    logic [31:0] imem [64];
    logic [15:0] dmem [64];
    int          pc;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;

    always #10 clk = ~clk;

    nib_seq_core u0 (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_re(dmem_re), .dmem_rdata(dmem_rdata),
        .halted(halted), .psw(psw)
    );

    // Memory models with one-cycle read latency.
    always @(posedge clk) begin
        imem_rdata <= imem[imem_addr[5:0]];
        if (dmem_we) dmem[dmem_addr[5:0]] <= dmem_wdata;
        dmem_rdata <= dmem[dmem_addr[5:0]];
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) begin
            imem[i] = '0;
            dmem[i] = '0;
        end
        pc = 0;
    endtask

    task automatic put_nib(int p, logic [3:0] v);
        imem[p / 8][31 - 4 * (p % 8) -: 4] = v;
    endtask

    task automatic emit20(logic [7:0] op, logic [3:0] a, logic [3:0] b, logic [3:0] d);
        logic [19:0] bits = {op, a, b, d};
        for (int k = 0; k < 5; k++) put_nib(pc + k, bits[19 - 4 * k -: 4]);
        pc += 5;
    endtask

    task automatic emit32(logic [7:0] op, logic [3:0] r1, logic [3:0] r2, logic [15:0] opd);
        logic [31:0] bits = {op, r1, r2, opd};
        for (int k = 0; k < 8; k++) put_nib(pc + k, bits[31 - 4 * k -: 4]);
        pc += 8;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_to_halt(string req);
        int n = 0;
        while (!halted && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(req, {31'b0, halted}, 32'd1);
    endtask

    // R3, R9: a lone halt, exact timing, then frozen port.
    task automatic t_halt();
        logic [12:0] a0;
        clear_mem();
        emit20(OP_HALT, 0, 0, 0);
        do_reset();
        repeat (6) @(negedge clk);
        chk("R3 not halted after 6 edges", {31'b0, halted}, 32'd0);
        @(negedge clk);
        chk("R3 halted after 7 edges", {31'b0, halted}, 32'd1);
        a0 = imem_addr;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!halted || imem_addr !== a0 || dmem_we) begin
                chk("R9 frozen after halt", {halted, dmem_we, 17'b0, imem_addr}, {1'b1, 1'b0, 17'b0, a0});
            end
        end
        chk("R9 still halted", {31'b0, halted}, 32'd1);
    endtask

    // R2, R4, R5, R6, R12: mixed lengths with misaligned starts.
    task automatic t_alu();
        clear_mem();
        dmem[0] = 16'hA5C3; dmem[1] = 16'h0F0F; dmem[2] = 16'h0004;
        emit32(OP_LOAD, 1, 0, 16'd0);
        emit32(OP_LOAD, 2, 0, 16'd1);
        emit32(OP_LOAD, 3, 0, 16'd2);
        emit20(OP_ADD, 1, 2, 4);
        emit20(OP_AND, 1, 2, 5);
        emit20(OP_OR,  1, 2, 6);
        emit20(OP_XOR, 1, 2, 7);
        emit20(OP_NOT, 1, 0, 8);
        emit20(OP_SHL, 1, 3, 9);
        emit20(OP_SHR, 1, 3, 10);
        emit20(OP_SAR, 1, 3, 11);
        emit20(OP_ADD, 2, 3, 0);
        emit20(OP_SAR, 2, 3, 12);
        for (int r = 4; r <= 11; r++) emit32(OP_STORE, 4'(r), 0, 16'(12 + r));
        emit32(OP_STORE, 0, 0, 16'd24);
        emit32(OP_STORE, 12, 0, 16'd25);
        emit20(OP_HALT, 0, 0, 0);
        do_reset();
        run_to_halt("R2 alu program halts");
        chk("R4 ADD",  dmem[16], 16'hB4D2);
        chk("R4 AND",  dmem[17], 16'h0503);
        chk("R4 OR",   dmem[18], 16'hAFCF);
        chk("R4 XOR",  dmem[19], 16'hAACC);
        chk("R4 NOT",  dmem[20], 16'h5A3C);
        chk("R5 SHL",  dmem[21], 16'h5C30);
        chk("R5 SHR",  dmem[22], 16'h0A5C);
        chk("R5 SAR negative", dmem[23], 16'hFA5C);
        chk("R12 reg0 writable", dmem[24], 16'h0F13);
        chk("R5 SAR positive", dmem[25], 16'h00F0);
        chk("R2 no illegal decode", {27'b0, psw[4]}, 32'd0);
    endtask

    // R10: flag results of two additions.
    task automatic t_flags();
        clear_mem();
        dmem[0] = 16'h7FFF; dmem[1] = 16'h0001;
        emit32(OP_LOAD, 1, 0, 16'd0);
        emit32(OP_LOAD, 2, 0, 16'd1);
        emit20(OP_ADD, 1, 2, 3);
        emit20(OP_HALT, 0, 0, 0);
        do_reset();
        run_to_halt("R10 run A halts");
        chk("R10 ovf+neg", {27'b0, psw}, 32'h0C);
        clear_mem();
        dmem[0] = 16'hFFFF; dmem[1] = 16'h0001;
        emit32(OP_LOAD, 1, 0, 16'd0);
        emit32(OP_LOAD, 2, 0, 16'd1);
        emit20(OP_ADD, 1, 2, 3);
        emit32(OP_STORE, 3, 0, 16'd5);
        emit20(OP_HALT, 0, 0, 0);
        do_reset();
        run_to_halt("R10 run B halts");
        chk("R10 zero+carry kept over store", {27'b0, psw}, 32'h03);
        chk("R10 sum wraps", dmem[5], 16'h0000);
    endtask

    // R7, R8: taken and untaken conditional branch, unconditional jump.
    task automatic t_branch();
        clear_mem();
        dmem[0] = 16'd5; dmem[1] = 16'd5; dmem[2] = 16'd7; dmem[3] = 16'hEEEE;
        emit32(OP_LOAD, 1, 0, 16'd0);
        emit32(OP_LOAD, 2, 0, 16'd1);
        emit32(OP_LOAD, 3, 0, 16'd2);
        emit32(OP_LOAD, 9, 0, 16'd3);
        emit20(OP_CEQ, 1, 2, 4);
        emit20(OP_CEQ, 1, 3, 5);
        emit32(OP_BRT, 4, 0, 16'(pc + 16));
        emit32(OP_STORE, 9, 0, 16'd30);
        emit32(OP_BRT, 5, 0, 16'(pc + 16));
        emit32(OP_STORE, 9, 0, 16'd31);
        emit32(OP_JMP, 0, 0, 16'(pc + 16));
        emit32(OP_STORE, 9, 0, 16'd32);
        emit32(OP_STORE, 4, 0, 16'd33);
        emit32(OP_STORE, 5, 0, 16'd34);
        emit20(OP_HALT, 0, 0, 0);
        do_reset();
        run_to_halt("R7 branch program halts");
        chk("R8 taken branch skips store", dmem[30], 16'h0000);
        chk("R8 untaken branch falls through", dmem[31], 16'hEEEE);
        chk("R7 jump skips store", dmem[32], 16'h0000);
        chk("R4 compare equal true", dmem[33], 16'h0001);
        chk("R4 compare equal false", dmem[34], 16'h0000);
    endtask

    // R11: undefined op code halts before the next instruction.
    task automatic t_illegal();
        clear_mem();
        dmem[0] = 16'h1111;
        emit32(OP_LOAD, 1, 0, 16'd0);
        emit20(8'h3F, 0, 0, 0);
        emit32(OP_STORE, 1, 0, 16'd40);
        emit20(OP_HALT, 0, 0, 0);
        do_reset();
        run_to_halt("R11 illegal halts");
        chk("R11 err flag only", {27'b0, psw}, 32'h10);
        repeat (10) @(negedge clk);
        chk("R11 later store not done", dmem[40], 16'h0000);
    endtask

    // R1: reset clears pointer, flags, halt state and registers.
    task automatic t_reset();
        clear_mem();
        dmem[50] = 16'hBEEF;
        emit32(OP_STORE, 1, 0, 16'd50);
        emit20(OP_HALT, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 psw cleared", {27'b0, psw}, 32'h0);
        chk("R1 halted cleared", {31'b0, halted}, 32'd0);
        chk("R1 fetch at 0", {19'b0, imem_addr}, 32'd0);
        rst_n = 1'b1;
        run_to_halt("R1 run after reset halts");
        chk("R1 register cleared", dmem[50], 16'h0000);
    endtask

    initial begin
        clear_mem();
        t_halt();
        t_alu();
        t_flags();
        t_branch();
        t_illegal();
        t_reset();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule